// File: doc/BRIEF.md
# Card Clock Divider with Update Handshake

This block derives a card clock from the reference clock through a programmable even divider and an on/off control. Software writes the divider and enable values into holding registers. These writes have no effect on the running clock. The values move to the active settings only when a command that requests a clock update alone is accepted. That command sends nothing on the card bus. With this scheme the output frequency and gating change in one step, at a point that software chooses.

The start bit of the command register stays set while the block holds a command. It clears one cycle after the command is accepted, so software can poll it for completion. A command can ask to wait for a data-busy input to fall before it is accepted. A second command written while the start bit is still set is discarded. Instead, a sticky lock error flag is raised, and software clears it with a write-one-to-clear.

Top module: `cclk_gen`

## Requirements
- R1: After reset the card clock output is low, the start-busy output is low, the lock error is low and the active enable is off.
- R2: Writes to the divider and enable holding registers do not change the card clock output until an update command is accepted.
- R3: A command write with bit 31 set makes start-busy rise on the next cycle. When no wait applies, start-busy stays high for exactly two cycles and then clears.
- R4: With an active divider D greater than zero and the clock enabled, the card clock has a period of 2·D reference cycles and is high for D of them.
- R5: With an active divider of zero and the clock enabled, the card clock equals the reference clock.
- R6: When the active enable (holding-register bit 0) is off, the card clock is held low.
- R7: A command with bit 13 set is not accepted while the data-busy input is high, and start-busy stays set until that input falls. Without bit 13 the data-busy input is ignored.
- R8: A command write with bit 31 set while start-busy is high sets the lock error and is discarded: it loads nothing and does not extend start-busy.
- R9: The lock error remains set until a clear write with bit 12 set. A clear write without bit 12 leaves it set.
- R10: A command write with bit 31 clear while idle is ignored: start-busy stays low.
- R11: An accepted command with bit 21 clear does not load the holding registers into the active settings. Only commands with bit 21 set do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| div_we_i | input | 1 | Write strobe for the divider holding register |
| div_wdata_i | input | DIV_W | Divider value to hold |
| ena_we_i | input | 1 | Write strobe for the enable holding register |
| ena_wdata_i | input | 1 | Enable value to hold (bit 0 of the enable register) |
| cmd_we_i | input | 1 | Write strobe for the command register |
| cmd_wdata_i | input | CMD_W | Command word (bit 31 start, bit 21 update only, bit 13 wait) |
| clr_we_i | input | 1 | Write strobe for the raw status clear |
| clr_wdata_i | input | CMD_W | Clear mask, bit 12 clears the lock error |
| data_busy_i | input | 1 | Data-busy condition from the data path |
| cclk_o | output | 1 | Divided card clock |
| start_busy_o | output | 1 | Start bit of the command register |
| hle_o | output | 1 | Sticky lock error flag |

## Verification
The checker watches several rules on every cycle. The active settings may change only while start-busy is high. A command written while busy must set the lock error. The error must persist until a clear with bit 12. A start-less command write must leave the block idle. The card clock must be low whenever the active enable is off. Other properties need an observation window that only the bench's scenarios provide: the exact two-cycle start-busy length, the period and duty of the divided clock, the pass-through at divider zero, holding against data busy, and the fact that discarded or non-update commands leave the old frequency running.

// File: rtl/cclk_pkg.sv
package cclk_pkg;
    localparam int START_POS = 31;
    localparam int UPD_POS   = 21;
    localparam int WAIT_POS  = 13;
    localparam int LOCK_POS  = 12;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PEND   = 2'd1,
        ST_RETIRE = 2'd2
    } cmd_st_e;
endpackage

// File: rtl/cclk_cmd_ctrl.sv
module cclk_cmd_ctrl
    import cclk_pkg::*;
#(
    parameter int CMD_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cmd_we_i,
    input  logic [CMD_W-1:0] cmd_wdata_i,
    input  logic             clr_we_i,
    input  logic [CMD_W-1:0] clr_wdata_i,
    input  logic             data_busy_i,
    output logic             load_o,
    output logic             start_busy_o,
    output logic             hle_o
);
    typedef struct packed {
        cmd_st_e st;
        logic    upd;
        logic    wt;
        logic    hle;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  new_cmd;

    always_comb begin
        ctrl_d  = ctrl_q;
        load_o  = 1'b0;
        new_cmd = cmd_we_i && cmd_wdata_i[START_POS];
        case (ctrl_q.st)
            ST_IDLE: begin
                if (new_cmd) begin
                    ctrl_d.st  = ST_PEND;
                    ctrl_d.upd = cmd_wdata_i[UPD_POS];
                    ctrl_d.wt  = cmd_wdata_i[WAIT_POS];
                end
            end
            ST_PEND: begin
                if (!(ctrl_q.wt && data_busy_i)) begin
                    load_o    = ctrl_q.upd;
                    ctrl_d.st = ST_RETIRE;
                end
            end
            default: ctrl_d.st = ST_IDLE;
        endcase
        if (clr_we_i && clr_wdata_i[LOCK_POS]) ctrl_d.hle = 1'b0;
        if (new_cmd && ctrl_q.st != ST_IDLE)    ctrl_d.hle = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctrl_q <= '{st: ST_IDLE, upd: 1'b0, wt: 1'b0, hle: 1'b0};
        else         ctrl_q <= ctrl_d;
    end

    assign start_busy_o = (ctrl_q.st != ST_IDLE);
    assign hle_o        = ctrl_q.hle;
endmodule

// File: rtl/cclk_cfg_regs.sv
module cclk_cfg_regs #(
    parameter int DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             div_we_i,
    input  logic [DIV_W-1:0] div_wdata_i,
    input  logic             ena_we_i,
    input  logic             ena_wdata_i,
    input  logic             load_i,
    output logic [DIV_W-1:0] act_div_o,
    output logic             act_ena_o
);
    typedef struct packed {
        logic [DIV_W-1:0] sh_div;
        logic             sh_ena;
        logic [DIV_W-1:0] act_div;
        logic             act_ena;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (div_we_i) cfg_d.sh_div = div_wdata_i;
        if (ena_we_i) cfg_d.sh_ena = ena_wdata_i;
        if (load_i) begin
            cfg_d.act_div = cfg_q.sh_div;
            cfg_d.act_ena = cfg_q.sh_ena;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    assign act_div_o = cfg_q.act_div;
    assign act_ena_o = cfg_q.act_ena;
endmodule

// File: rtl/cclk_div.sv
module cclk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DIV_W-1:0] div_i,
    input  logic             ena_i,
    input  logic             restart_i,
    output logic             cclk_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             lvl;
    } div_t;

    div_t div_d, div_q;
    logic bypass;

    always_comb begin
        div_d = div_q;
        if (restart_i || !ena_i) begin
            div_d.cnt = '0;
            div_d.lvl = 1'b0;
        end else if (div_i != '0) begin
            if (div_q.cnt == div_i - DIV_W'(1)) begin
                div_d.cnt = '0;
                div_d.lvl = ~div_q.lvl;
            end else begin
                div_d.cnt = div_q.cnt + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) div_q <= '0;
        else         div_q <= div_d;
    end

    // divider zero passes the reference through while enabled
    assign bypass = ena_i && (div_i == '0);
    assign cclk_o = bypass ? clk_i : div_q.lvl;
endmodule

// File: rtl/cclk_gen.sv
module cclk_gen #(
    parameter int DIV_W = 8,
    parameter int CMD_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             div_we_i,
    input  logic [DIV_W-1:0] div_wdata_i,
    input  logic             ena_we_i,
    input  logic             ena_wdata_i,
    input  logic             cmd_we_i,
    input  logic [CMD_W-1:0] cmd_wdata_i,
    input  logic             clr_we_i,
    input  logic [CMD_W-1:0] clr_wdata_i,
    input  logic             data_busy_i,
    output logic             cclk_o,
    output logic             start_busy_o,
    output logic             hle_o
);
    logic             load;
    logic [DIV_W-1:0] act_div;
    logic             act_ena;

    cclk_cmd_ctrl #(.CMD_W(CMD_W)) u_ctrl (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .cmd_we_i     (cmd_we_i),
        .cmd_wdata_i  (cmd_wdata_i),
        .clr_we_i     (clr_we_i),
        .clr_wdata_i  (clr_wdata_i),
        .data_busy_i  (data_busy_i),
        .load_o       (load),
        .start_busy_o (start_busy_o),
        .hle_o        (hle_o)
    );

    cclk_cfg_regs #(.DIV_W(DIV_W)) u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .div_we_i    (div_we_i),
        .div_wdata_i (div_wdata_i),
        .ena_we_i    (ena_we_i),
        .ena_wdata_i (ena_wdata_i),
        .load_i      (load),
        .act_div_o   (act_div),
        .act_ena_o   (act_ena)
    );

    cclk_div #(.DIV_W(DIV_W)) u_div (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .div_i     (act_div),
        .ena_i     (act_ena),
        .restart_i (load),
        .cclk_o    (cclk_o)
    );
endmodule

// File: rtl/cclk_gen_chk.sv
module cclk_gen_chk
    import cclk_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int CMD_W = 32
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             cmd_we_i,
    input logic [CMD_W-1:0] cmd_wdata_i,
    input logic             clr_we_i,
    input logic [CMD_W-1:0] clr_wdata_i,
    input logic             start_busy_o,
    input logic             hle_o,
    input logic             cclk_o,
    input logic [DIV_W-1:0] act_div,
    input logic             act_ena
);
    // R2: active settings move only while a command is held
    a_r2_active_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !start_busy_o |=> ($stable(act_div) && $stable(act_ena)));

    // R8: a started command while busy raises the lock error
    a_r8_lock_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_we_i && cmd_wdata_i[START_POS] && start_busy_o) |=> hle_o);

    // R9: lock error is sticky until cleared through bit 12
    a_r9_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hle_o && !(clr_we_i && clr_wdata_i[LOCK_POS])) |=> hle_o);

    // R10: a write without the start bit leaves an idle block idle
    a_r10_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!start_busy_o && !(cmd_we_i && cmd_wdata_i[START_POS])) |=> !start_busy_o);

    // R6: disabled clock stays low
    a_r6_gated_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !act_ena |-> !cclk_o);
endmodule

bind cclk_gen cclk_gen_chk #(.DIV_W(DIV_W), .CMD_W(CMD_W)) u_chk (.*);

// File: tb/sim_cclk_gen.sv
module sim_cclk_gen;
    localparam int DW = 8;
    localparam int CW = 32;
    localparam logic [CW-1:0] UPD_WAIT = 32'h8020_2000;
    localparam logic [CW-1:0] UPD_NOW  = 32'h8020_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          div_we = 1'b0;
    logic [DW-1:0] div_wd = '0;
    logic          ena_we = 1'b0;
    logic          ena_wd = 1'b0;
    logic          cmd_we = 1'b0;
    logic [CW-1:0] cmd_wd = '0;
    logic          clr_we = 1'b0;
    logic [CW-1:0] clr_wd = '0;
    logic          busy = 1'b0;
    logic          cclk, start_busy, hle;

    int n_total = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    cclk_gen #(.DIV_W(DW), .CMD_W(CW)) u0 (
        .clk_i(clk), .rst_ni(rst_n),
        .div_we_i(div_we), .div_wdata_i(div_wd),
        .ena_we_i(ena_we), .ena_wdata_i(ena_wd),
        .cmd_we_i(cmd_we), .cmd_wdata_i(cmd_wd),
        .clr_we_i(clr_we), .clr_wdata_i(clr_wd),
        .data_busy_i(busy),
        .cclk_o(cclk), .start_busy_o(start_busy), .hle_o(hle)
    );

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_div(input logic [DW-1:0] v);
        div_we = 1'b1; div_wd = v; tick(); div_we = 1'b0;
    endtask

    task automatic wr_ena(input logic v);
        ena_we = 1'b1; ena_wd = v; tick(); ena_we = 1'b0;
    endtask

    task automatic wr_cmd(input logic [CW-1:0] v);
        cmd_we = 1'b1; cmd_wd = v; tick(); cmd_we = 1'b0;
    endtask

    task automatic wr_clr(input logic [CW-1:0] v);
        clr_we = 1'b1; clr_wd = v; tick(); clr_we = 1'b0;
    endtask

    task automatic update(input logic [DW-1:0] d, input logic e);
        wr_div(d); wr_ena(e); wr_cmd(UPD_WAIT); tick(); tick();
    endtask

    task automatic measure(input int d, input string tag);
        int highs = 0;
        int rises = 0;
        logic prev = cclk;
        for (int i = 0; i < 8 * d; i++) begin
            tick();
            if (cclk) highs++;
            if (cclk && !prev) rises++;
            prev = cclk;
        end
        chk(highs == 4 * d, {tag, " high count"}, highs, 4 * d);
        chk(rises == 4, {tag, " period count"}, rises, 4);
    endtask

    task automatic t_reset();
        chk(cclk == 1'b0, "R1 cclk", cclk, 0);
        chk(start_busy == 1'b0, "R1 start", start_busy, 0);
        chk(hle == 1'b0, "R1 hle", hle, 0);
    endtask

    task automatic t_shadow_only();
        int highs = 0;
        wr_div(8'd2); wr_ena(1'b1);
        for (int i = 0; i < 12; i++) begin tick(); if (cclk) highs++; end
        chk(highs == 0, "R2 no clock before update", highs, 0);
    endtask

    task automatic t_handshake();
        wr_cmd(UPD_WAIT);
        chk(start_busy == 1'b1, "R3 start after write", start_busy, 1);
        tick();
        chk(start_busy == 1'b1, "R3 start second cycle", start_busy, 1);
        tick();
        chk(start_busy == 1'b0, "R3 start cleared", start_busy, 0);
        measure(2, "R4 div2");
        update(8'd3, 1'b1);
        measure(3, "R4 div3");
    endtask

    task automatic t_lock();
        wr_div(8'd2);
        wr_cmd(UPD_WAIT);
        wr_cmd(UPD_WAIT);
        chk(hle == 1'b1, "R8 lock set", hle, 1);
        chk(start_busy == 1'b1, "R8 first still busy", start_busy, 1);
        tick();
        chk(start_busy == 1'b0, "R8 not extended", start_busy, 0);
        wr_div(8'd6);
        repeat (4) tick();
        measure(2, "R8 second cmd discarded");
    endtask

    task automatic t_lock_clear();
        wr_clr(32'h0000_0ffe);
        chk(hle == 1'b1, "R9 kept without bit12", hle, 1);
        wr_clr(32'h0000_1000);
        chk(hle == 1'b0, "R9 cleared by bit12", hle, 0);
    endtask

    task automatic t_no_start();
        wr_div(8'd4);
        wr_cmd(32'h0020_2000);
        chk(start_busy == 1'b0, "R10 start low", start_busy, 0);
        tick();
        chk(start_busy == 1'b0, "R10 still idle", start_busy, 0);
        measure(2, "R10 no load");
    endtask

    task automatic t_non_update();
        wr_cmd(32'h8000_0011);
        chk(start_busy == 1'b1, "R11 start set", start_busy, 1);
        tick(); tick();
        chk(start_busy == 1'b0, "R11 retired", start_busy, 0);
        measure(2, "R11 no load");
        wr_cmd(UPD_WAIT); tick(); tick();
        measure(4, "R11 update loads");
    endtask

    task automatic t_bypass();
        int bad = 0;
        update(8'd0, 1'b1);
        for (int i = 0; i < 6; i++) begin
            tick();
            if (cclk !== 1'b1) bad++;
            @(negedge clk); #1;
            if (cclk !== 1'b0) bad++;
        end
        chk(bad == 0, "R5 follows reference", bad, 0);
    endtask

    task automatic t_disable();
        int highs = 0;
        update(8'd2, 1'b0);
        for (int i = 0; i < 20; i++) begin
            tick(); if (cclk) highs++;
            @(negedge clk); #1; if (cclk) highs++;
        end
        chk(highs == 0, "R6 gated low", highs, 0);
    endtask

    task automatic t_wait();
        busy = 1'b1;
        wr_div(8'd1); wr_ena(1'b1);
        wr_cmd(UPD_WAIT);
        repeat (10) tick();
        chk(start_busy == 1'b1, "R7 held by busy", start_busy, 1);
        chk(cclk == 1'b0, "R7 not loaded", cclk, 0);
        busy = 1'b0;
        tick();
        chk(start_busy == 1'b1, "R7 retiring", start_busy, 1);
        tick();
        chk(start_busy == 1'b0, "R7 done", start_busy, 0);
        measure(1, "R7 div1");
        busy = 1'b1;
        wr_div(8'd3);
        wr_cmd(UPD_NOW); tick(); tick();
        chk(start_busy == 1'b0, "R7 no wait bit ignores busy", start_busy, 0);
        busy = 1'b0;
        measure(3, "R7 no wait loaded");
    endtask

    initial begin
        repeat (3) tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_shadow_only();
        t_handshake();
        t_lock();
        t_lock_clear();
        t_no_start();
        t_non_update();
        t_bypass();
        t_disable();
        t_wait();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule